// File: doc/BRIEF.md
# Symbol Rate Ratio Calculator

This block turns a requested symbol rate, in symbols per second, into the two settings a QPSK demodulator's timing loop needs. The first is a sampling-clock multiplier for a fixed 10.111 MHz reference crystal. The second is a 22-bit fractional rate word. The multiplier is the smallest step whose sampling rate is high enough for the requested rate. The rate word is the requested rate divided by the resulting sample rate, scaled by 2^23.

A caller pulses `start_i` with the rate on `rate_i`. If the block is idle and the rate is in range, it raises `busy_o`. A restoring divider then produces one quotient bit per clock, in four chunks of 6, 6, 6 and 5 bits. All intermediates fit in 32 bits. When the last bit is in place, `done_o` pulses and the result registers update together. A rate outside the accepted window gives a one-cycle error pulse and leaves every result register as it was.

Top module: `srr_calc`

## Requirements
- R1: Rates from 1,000,000 to 45,000,000 inclusive are accepted. Any other rate presented on an idle start raises `err_o` for exactly one cycle, starting the cycle after the start. Busy stays low and no result output changes.
- R2: `mult_code_o` is the smallest m in 2..8 with rate < m × 10,111,000 / 2. It is 9 when no such m exists.
- R3: `mult_word_o` equals six times the selected multiplier.
- R4: The 22-bit ratio equals floor(rate × 2^23 / (m × 10,111,000)), exactly as a 64-bit division would give it.
- R5: The ratio is presented as three bytes. `ratio_hi_o` holds ratio bits 21:16 in its bits 5:0, with bits 7:6 zero. `ratio_mid_o` holds bits 15:8 and `ratio_lo_o` holds bits 7:0.
- R6: After an accepted start sampled at edge E0, `busy_o` is high from E0 until E23. At E23 `busy_o` falls, `done_o` rises for exactly one cycle and all results become valid. The results hold until the next accepted start completes.
- R7: A start while `busy_o` is high is ignored. The running computation finishes with its own rate, on schedule, with one done pulse and no error.
- R8: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| rate_i | input | 32 | Requested symbol rate, symbols/s |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle out-of-range pulse |
| mult_code_o | output | 4 | Selected multiplier (2..9) |
| mult_word_o | output | 8 | Multiplier times six |
| ratio_hi_o | output | 8 | Ratio bits 21:16, top two bits zero |
| ratio_mid_o | output | 8 | Ratio bits 15:8 |
| ratio_lo_o | output | 8 | Ratio bits 7:0 |

## Verification
For an accepted rate, busy is due one edge after the start and done exactly 23 edges after that. The bench counts falling edges from the start edge to the done pulse and checks the count is 23. It checks the results in that same half-cycle and confirms done is gone one cycle later. A rejected rate must show its error one edge after the start and must be gone one edge later. The bench samples there and compares the result outputs with the values held from the previous accepted run.

// File: rtl/srr_pkg.sv
package srr_pkg;

  // Scale applied to the multiplier before it is presented as a register word
  localparam int unsigned WORD_SCALE = 6;

  // Sample-rate threshold for multiplier m: rate must lie below m*xtal/2
  function automatic logic [63:0] srr_threshold(input int unsigned m, input int unsigned xtal);
    logic [63:0] prod;
    prod = 64'(m) * 64'(xtal);
    return prod >> 1;
  endfunction

endpackage

// File: rtl/srr_mult_sel.sv
module srr_mult_sel import srr_pkg::*; #(
  parameter int unsigned XTAL_HZ  = 10111000,
  parameter int unsigned MULT_MIN = 2,
  parameter int unsigned MULT_MAX = 9,
  parameter int unsigned RATE_W   = 32,
  parameter int unsigned MW       = 4
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic [MW-1:0]     mult_o
);

  localparam int unsigned NSTEP = MULT_MAX - MULT_MIN;

  logic [NSTEP-1:0] below;

  // One comparator per staircase step
  for (genvar g = 0; g < NSTEP; g++) begin : g_step
    assign below[g] = 64'(rate_i) < srr_threshold(MULT_MIN + g, XTAL_HZ);
  end

  // Lowest step that clears the rate wins
  always_comb begin
    mult_o = MW'(MULT_MAX);
    for (int i = NSTEP - 1; i >= 0; i--) begin
      if (below[i]) mult_o = MW'(MULT_MIN + i);
    end
  end

endmodule

// File: rtl/srr_seq.sv
module srr_seq #(
  parameter int unsigned FRAC_BITS  = 23,
  parameter int unsigned CHUNK_BITS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o,
  output logic step_o,
  output logic fin_o,
  output logic done_o
);

  localparam int unsigned NCHUNK   = (FRAC_BITS + CHUNK_BITS - 1) / CHUNK_BITS;
  localparam int unsigned LAST_LEN = FRAC_BITS - (NCHUNK - 1) * CHUNK_BITS;
  localparam int unsigned CW       = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
  localparam int unsigned BW       = (CHUNK_BITS > 1) ? $clog2(CHUNK_BITS) : 1;

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] chunk_q, chunk_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          last_chunk, chunk_end, last_bit;

  assign last_chunk = (chunk_q == CW'(NCHUNK - 1));
  assign chunk_end  = last_chunk ? (bit_q == BW'(LAST_LEN - 1))
                                 : (bit_q == BW'(CHUNK_BITS - 1));
  assign last_bit   = last_chunk && chunk_end;

  always_comb begin
    busy_d  = busy_q;
    chunk_d = chunk_q;
    bit_d   = bit_q;
    done_d  = 1'b0;
    if (load_i) begin
      busy_d  = 1'b1;
      chunk_d = '0;
      bit_d   = '0;
    end else if (busy_q) begin
      if (last_bit) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else if (chunk_end) begin
        chunk_d = chunk_q + CW'(1);
        bit_d   = '0;
      end else begin
        bit_d = bit_q + BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      chunk_q <= '0;
      bit_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      chunk_q <= chunk_d;
      bit_q   <= bit_d;
    end
  end

  assign busy_o = busy_q;
  assign step_o = busy_q;
  assign fin_o  = busy_q && last_bit;
  assign done_o = done_q;

  // R7: the caller never loads while a run is active
  p_no_load_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_q);

  // R6: a run in progress keeps going until its final bit
  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_bit) |=> busy_q);

endmodule

// File: rtl/srr_divider.sv
module srr_divider #(
  parameter int unsigned DIV_W     = 32,
  parameter int unsigned FRAC_BITS = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 step_i,
  input  logic [DIV_W-1:0]     dividend_i,
  input  logic [DIV_W-1:0]     divisor_i,
  output logic [FRAC_BITS-1:0] quot_nx_o
);

  logic [DIV_W-1:0]     rem_q, rem_d, div_q, div_d;
  logic [FRAC_BITS-1:0] quot_q, quot_d;
  logic [DIV_W:0]       rem_sh;
  logic                 ge;
  logic [DIV_W-1:0]     rem_nx;
  logic [FRAC_BITS-1:0] quot_nx;

  // One restoring step: double the remainder, subtract when it fits
  assign rem_sh  = {rem_q, 1'b0};
  assign ge      = rem_sh >= {1'b0, div_q};
  assign rem_nx  = ge ? DIV_W'(rem_sh - {1'b0, div_q}) : DIV_W'(rem_sh);
  assign quot_nx = {quot_q[FRAC_BITS-2:0], ge};

  always_comb begin
    rem_d  = rem_q;
    div_d  = div_q;
    quot_d = quot_q;
    if (load_i) begin
      rem_d  = dividend_i;
      div_d  = divisor_i;
      quot_d = '0;
    end else if (step_i) begin
      rem_d  = rem_nx;
      quot_d = quot_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      div_q  <= '0;
      quot_q <= '0;
    end else begin
      rem_q  <= rem_d;
      div_q  <= div_d;
      quot_q <= quot_d;
    end
  end

  assign quot_nx_o = quot_nx;

  // R4: the partial remainder stays below the divisor on every step
  p_rem_below_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (rem_q < div_q));

endmodule

// File: rtl/srr_calc.sv
module srr_calc import srr_pkg::*; #(
  parameter int unsigned XTAL_HZ    = 10111000,
  parameter int unsigned RATE_MIN   = 1000000,
  parameter int unsigned RATE_MAX   = 45000000,
  parameter int unsigned MULT_MIN   = 2,
  parameter int unsigned MULT_MAX   = 9,
  parameter int unsigned FRAC_BITS  = 23,
  parameter int unsigned CHUNK_BITS = 6,
  parameter int unsigned RATE_W     = 32,
  parameter int unsigned MW         = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [MW-1:0]     mult_code_o,
  output logic [7:0]        mult_word_o,
  output logic [7:0]        ratio_hi_o,
  output logic [7:0]        ratio_mid_o,
  output logic [7:0]        ratio_lo_o
);

  // Reset asserts at once and is released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                 busy, step, fin, done;
  logic                 in_range, accept, reject;
  logic [MW-1:0]        m_sel;
  logic [RATE_W-1:0]    divisor;
  logic [FRAC_BITS-1:0] quot_nx;

  logic [MW-1:0] m_hold_q, m_hold_d;
  logic          err_q, err_d;
  logic [MW-1:0] code_q, code_d;
  logic [7:0]    word_q, word_d, hi_q, hi_d, mid_q, mid_d, lo_q, lo_d;

  assign in_range = (rate_i >= RATE_W'(RATE_MIN)) && (rate_i <= RATE_W'(RATE_MAX));
  assign accept   = start_i && !busy && in_range;
  assign reject   = start_i && !busy && !in_range;
  assign divisor  = RATE_W'(m_sel) * RATE_W'(XTAL_HZ);

  srr_mult_sel #(
    .XTAL_HZ(XTAL_HZ), .MULT_MIN(MULT_MIN), .MULT_MAX(MULT_MAX),
    .RATE_W(RATE_W), .MW(MW)
  ) u_sel (
    .rate_i(rate_i),
    .mult_o(m_sel)
  );

  srr_seq #(
    .FRAC_BITS(FRAC_BITS), .CHUNK_BITS(CHUNK_BITS)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .load_i(accept),
    .busy_o(busy), .step_o(step), .fin_o(fin), .done_o(done)
  );

  srr_divider #(
    .DIV_W(RATE_W), .FRAC_BITS(FRAC_BITS)
  ) u_div (
    .clk(clk), .rst_n(rst_int_n), .load_i(accept), .step_i(step),
    .dividend_i(rate_i), .divisor_i(divisor), .quot_nx_o(quot_nx)
  );

  always_comb begin
    m_hold_d = accept ? m_sel : m_hold_q;
    err_d    = reject;
    code_d   = code_q;
    word_d   = word_q;
    hi_d     = hi_q;
    mid_d    = mid_q;
    lo_d     = lo_q;
    if (fin) begin
      code_d = m_hold_q;
      word_d = 8'(m_hold_q) * 8'(WORD_SCALE);
      hi_d   = {2'b00, quot_nx[21:16]};
      mid_d  = quot_nx[15:8];
      lo_d   = quot_nx[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      m_hold_q <= '0;
      err_q    <= 1'b0;
      code_q   <= '0;
      word_q   <= '0;
      hi_q     <= '0;
      mid_q    <= '0;
      lo_q     <= '0;
    end else begin
      m_hold_q <= m_hold_d;
      err_q    <= err_d;
      code_q   <= code_d;
      word_q   <= word_d;
      hi_q     <= hi_d;
      mid_q    <= mid_d;
      lo_q     <= lo_d;
    end
  end

  assign busy_o      = busy;
  assign done_o      = done;
  assign err_o       = err_q;
  assign mult_code_o = code_q;
  assign mult_word_o = word_q;
  assign ratio_hi_o  = hi_q;
  assign ratio_mid_o = mid_q;
  assign ratio_lo_o  = lo_q;

  // R6: completion is a single-cycle pulse outside the busy window
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> !done_o);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> !busy_o);

  // R1: a rejection starts nothing and leaves results untouched
  p_err_quiet_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    err_o |-> (!busy_o && !done_o));
  p_err_keeps_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    err_o |-> ($stable(ratio_lo_o) && $stable(ratio_hi_o) && $stable(mult_code_o)));

  // R2: the reported multiplier lies on the staircase
  p_mult_range_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> ((mult_code_o >= MW'(MULT_MIN)) && (mult_code_o <= MW'(MULT_MAX))));

  // R5: the top byte carries only six ratio bits
  p_hi_mask_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> (ratio_hi_o[7:6] == 2'b00));

endmodule

// File: tb/srr_calc_test.sv
module srr_calc_test;

  localparam longint XTAL = 10111000;
  localparam longint RMIN = 1000000;
  localparam longint RMAX = 45000000;

  logic        clk, rst_n, start_i;
  logic [31:0] rate_i;
  logic        busy_o, done_o, err_o;
  logic [3:0]  mult_code_o;
  logic [7:0]  mult_word_o, ratio_hi_o, ratio_mid_o, ratio_lo_o;

  int checks = 0;
  int fails  = 0;

  // results of the last accepted run, held for the rejection checks
  logic [3:0] last_code;
  logic [7:0] last_word, last_hi, last_mid, last_lo;

  srr_calc uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_i(rate_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .mult_code_o(mult_code_o), .mult_word_o(mult_word_o),
    .ratio_hi_o(ratio_hi_o), .ratio_mid_o(ratio_mid_o), .ratio_lo_o(ratio_lo_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected finished)");
    summary();
    $finish;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_mult(input longint r);
    int m = 9;
    for (int k = 8; k >= 2; k--) if (r < (k * XTAL) / 2) m = k;
    return m;
  endfunction

  function automatic longint exp_ratio(input longint r);
    return (r <<< 23) / (exp_mult(r) * XTAL);
  endfunction

  task automatic expect_results(input longint r, input string tag);
    longint q;
    int     m;
    q = exp_ratio(r);
    m = exp_mult(r);
    check({"R2 multiplier ", tag}, mult_code_o, m);
    check({"R3 multiplier word ", tag}, mult_word_o, m * 6);
    check({"R4 ratio ", tag}, {ratio_hi_o[5:0], ratio_mid_o, ratio_lo_o}, q);
    check({"R5 hi byte ", tag}, ratio_hi_o, (q >> 16) & 8'h3f);
    check({"R5 mid byte ", tag}, ratio_mid_o, (q >> 8) & 8'hff);
    check({"R5 lo byte ", tag}, ratio_lo_o, q & 8'hff);
  endtask

  task automatic hold_results();
    last_code = mult_code_o;
    last_word = mult_word_o;
    last_hi   = ratio_hi_o;
    last_mid  = ratio_mid_o;
    last_lo   = ratio_lo_o;
  endtask

  // Run one rate; optionally poke a second start mid-run (R7)
  task automatic run_rate(input longint r, input string tag, input bit poke);
    int lat;
    @(negedge clk);
    start_i = 1'b1;
    rate_i  = 32'(r);
    @(negedge clk);
    start_i = 1'b0;
    rate_i  = 32'd0;
    if (r >= RMIN && r <= RMAX) begin
      check({"R6 busy after start ", tag}, busy_o, 1);
      check({"R1 no error ", tag}, err_o, 0);
      lat = 1;
      while (!done_o && lat < 60) begin
        if (poke && lat == 5) begin
          start_i = 1'b1;
          rate_i  = 32'd30000000;
        end else if (poke && lat == 9) begin
          start_i = 1'b1;
          rate_i  = 32'd5;
        end else begin
          start_i = 1'b0;
          rate_i  = 32'd0;
        end
        @(negedge clk);
        if (err_o) check({"R7 no error from busy start ", tag}, err_o, 0);
        if (!done_o) lat++;
      end
      start_i = 1'b0;
      check({"R6 latency ", tag}, lat, 23);
      check({"R6 busy low at done ", tag}, busy_o, 0);
      expect_results(r, tag);
      hold_results();
      @(negedge clk);
      check({"R6 done one cycle ", tag}, done_o, 0);
      if (poke) begin
        repeat (30) begin
          @(negedge clk);
          if (done_o || busy_o) check("R7 ignored start began a run", 1, 0);
        end
        expect_results(r, {tag, " after ignored start"});
      end
    end else begin
      check({"R1 error pulse ", tag}, err_o, 1);
      check({"R1 no busy ", tag}, busy_o, 0);
      check({"R1 code kept ", tag}, mult_code_o, last_code);
      check({"R1 word kept ", tag}, mult_word_o, last_word);
      check({"R1 ratio kept ", tag}, {ratio_hi_o, ratio_mid_o, ratio_lo_o},
            {last_hi, last_mid, last_lo});
      @(negedge clk);
      check({"R1 error one cycle ", tag}, err_o, 0);
      check({"R1 still idle ", tag}, busy_o, 0);
    end
  endtask

  initial begin
    start_i = 1'b0;
    rate_i  = 32'd0;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: reset state
    check("R8 busy", busy_o, 0);
    check("R8 done", done_o, 0);
    check("R8 err", err_o, 0);
    check("R8 code", mult_code_o, 0);
    check("R8 word", mult_word_o, 0);
    check("R8 ratio", {ratio_hi_o, ratio_mid_o, ratio_lo_o}, 0);
    hold_results();

    // R1: rejection before any run, and range limits
    run_rate(999999, "below min", 0);
    run_rate(0, "zero", 0);
    run_rate(RMIN, "min", 0);
    run_rate(RMAX, "max", 0);
    run_rate(RMAX + 1, "above max", 0);
    run_rate(64'hFFFFFFFF, "all ones", 0);
    run_rate(RMIN - 1, "just below min", 0);

    // R2: each staircase threshold and its neighbours
    for (int k = 2; k <= 8; k++) begin
      longint t;
      t = (k * XTAL) / 2;
      run_rate(t - 1, $sformatf("thr%0d-1", k), 0);
      run_rate(t, $sformatf("thr%0d", k), 0);
      run_rate(t + 1, $sformatf("thr%0d+1", k), 0);
    end

    // R7: starts during busy are ignored
    run_rate(12345678, "poked run", 1);

    // R4: sweep across the whole range
    for (longint r = RMIN + 777; r <= RMAX; r += 153331)
      run_rate(r, $sformatf("sweep %0d", r), 0);

    summary();
    $finish;
  end

endmodule